// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block is a small register file that a host reaches over a plain synchronous bus: a byte address, 32-bit write data, a write strobe, and read data that follows the address with no wait. Every register except the two kick registers ignores writes until the unlock sequence has finished. In that sequence the first key goes to the first kick register and then the second key goes to the second kick register. The device-control register has a second guard: a separate lock key must sit in its lock register before a write takes effect.

Inside the bank are per-device enable fields with their decoded enable vector, a read-only status register that mirrors those fields with wider codes, a reset register that gives a one-cycle reset pulse per set bit, and a configuration word with write-once behaviour. Reads are always allowed. The block is meant to sit beside the chip's system bus and drive enables and resets for the peripherals.

Top module: `keyguard_regbank`

## Requirements
- R1: After reset the kick state reads 0, the lock flag is clear, every device is disabled (`dev_en_o` = 0), `rst_pulse_o` = 0 and the write-once register reads 0.
- R2: The kick state reads at address 0x00 as 0 (idle), 1 (first key seen) or 2 (open). Writing 0x83E70B13 to 0x00 gives state 1. Then writing 0x95A4F1E0 to 0x04 gives state 2.
- R3: A wrong key to either kick register, or the second key written while the state is not 1, returns the state to 0. The sequence must then start again at 0x00.
- R4: While the state is not 2, writes to the lock (0x08), device-control (0x0C), reset (0x14) and write-once (0x18) registers are dropped.
- R5: The lock flag is bit 0 at 0x08. An unlocked write of 0x0F0A0B00 sets it and any other unlocked value clears it. A device-control write with the flag clear is dropped.
- R6: Devices 0 to 3 use 2-bit fields at bits [2i+1:2i] of 0x0C. Code 1 enables a device and code 0 disables it. Codes 2 and 3 leave the device unchanged. A field reads back 1 when the device is enabled and 0 when it is disabled.
- R7: Devices 4 and 5 use fields [9:8] and [11:10]. Code 3 enables a device. No code disables it, so every other value leaves it unchanged. A field reads back 3 when enabled, else 0. Bit i of `dev_en_o` is device i.
- R8: Address 0x10 holds a 3-bit status field per device at bits [3i+2:3i]: 3'b001 when enabled and 3'b000 when disabled. Writes to 0x10 have no effect.
- R9: An accepted write to 0x14 drives its low 8 data bits on `rst_pulse_o` for exactly the one cycle after the write edge. Address 0x14 reads 0.
- R10: At 0x18, bits [7:0] take only the first accepted write after reset, and bit 16 reads 1 once that write has happened. Each bit in [15:8], once set to 1, stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| dev_en_o | output | 6 | Decoded per-device enables |
| rst_pulse_o | output | 8 | One-cycle peripheral reset pulses |

## Verification
The unlock logic is exercised with the correct order, with the second key arriving while already open, with the second key wrong, and with the first key wrong. This separates a sequence that is truly ordered from one that only checks key values. A single device-control word carries enable codes, disable codes and unused codes across both device groups. This shows whether fields are decoded one at a time and whether the non-disableable group really refuses to turn off. Writes to the write-once word vary both the frozen byte and the sticky byte, which separates "first write wins" from "bits only accumulate". Each guarded register is also written with the kick closed and with the lock clear.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_DEV  = 6;
  localparam int GRP0_CNT = 4;   // devices that can be disabled
  localparam int FIELD_W  = 2;
  localparam int STAT_W   = 3;
  localparam int RST_W    = 8;
  localparam int ONCE_W   = 8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h83E7_0B13;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h95A4_F1E0;
  localparam logic [DATA_W-1:0] KEY_LOCK   = 32'h0F0A_0B00;

  localparam int OFS_KICK_A = 8'h00;
  localparam int OFS_KICK_B = 8'h04;
  localparam int OFS_LOCK   = 8'h08;
  localparam int OFS_DEVCTL = 8'h0C;
  localparam int OFS_DEVSTS = 8'h10;
  localparam int OFS_RST    = 8'h14;
  localparam int OFS_ONCE   = 8'h18;

  localparam logic [STAT_W-1:0] STS_ON  = 3'b001;
  localparam logic [STAT_W-1:0] STS_OFF = 3'b000;
  localparam logic [FIELD_W-1:0] CODE_OFF = '0;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } kick_state_e;

  function automatic logic [FIELD_W-1:0] fn_en_code(input int id);
    return (id < GRP0_CNT) ? FIELD_W'(1) : FIELD_W'(3);
  endfunction

  function automatic logic fn_can_disable(input int id);
    return id < GRP0_CNT;
  endfunction

  function automatic int fn_field_lsb(input int id);
    return id * FIELD_W;
  endfunction
endpackage

// File: rtl/keyguard_kick.sv
module keyguard_kick
  import keyguard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output kick_state_e       state_o
);
  kick_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_a_i)
      state_d = (wdata_i == KEY_FIRST) ? KS_HALF : KS_IDLE;
    else if (wr_b_i)
      state_d = (state_q == KS_HALF && wdata_i == KEY_SECOND) ? KS_OPEN : KS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/keyguard_devctl.sv
module keyguard_devctl
  import keyguard_pkg::*;
#(
  parameter int N_DEV = NUM_DEV,
  localparam int CTL_W = N_DEV * FIELD_W,
  localparam int STS_W = N_DEV * STAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wfields_i,
  output logic [N_DEV-1:0] en_o,
  output logic [CTL_W-1:0] ctl_rb_o,
  output logic [STS_W-1:0] sts_o
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    localparam int                 LSB   = fn_field_lsb(g);
    localparam logic [FIELD_W-1:0] ENC   = fn_en_code(g);
    localparam logic               CANDS = fn_can_disable(g);
    logic [FIELD_W-1:0] fld;
    logic en_q;

    assign fld = wfields_i[LSB +: FIELD_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else if (wr_i) begin
        if (fld == ENC)                    en_q <= 1'b1;
        else if (CANDS && fld == CODE_OFF) en_q <= 1'b0;
      end
    end

    assign en_o[g]                    = en_q;
    assign ctl_rb_o[LSB +: FIELD_W]   = en_q ? ENC : CODE_OFF;
    assign sts_o[g*STAT_W +: STAT_W]  = en_q ? STS_ON : STS_OFF;
  end
endmodule

// File: rtl/keyguard_regbank.sv
module keyguard_regbank
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_DEV-1:0] dev_en_o,
  output logic [RST_W-1:0]   rst_pulse_o
);
  localparam int CTL_W = NUM_DEV * FIELD_W;
  localparam int STS_W = NUM_DEV * STAT_W;

  // address hits
  logic hit_ka, hit_kb, hit_lock, hit_ctl, hit_sts, hit_rst, hit_once;
  assign hit_ka   = addr_i == ADDR_W'(OFS_KICK_A);
  assign hit_kb   = addr_i == ADDR_W'(OFS_KICK_B);
  assign hit_lock = addr_i == ADDR_W'(OFS_LOCK);
  assign hit_ctl  = addr_i == ADDR_W'(OFS_DEVCTL);
  assign hit_sts  = addr_i == ADDR_W'(OFS_DEVSTS);
  assign hit_rst  = addr_i == ADDR_W'(OFS_RST);
  assign hit_once = addr_i == ADDR_W'(OFS_ONCE);

  kick_state_e kick_state;
  logic        kick_open;
  logic        lock_ok;
  logic        ctl_wr_ok;

  keyguard_kick u_kick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_a_i  (we_i && hit_ka),
    .wr_b_i  (we_i && hit_kb),
    .wdata_i (wdata_i),
    .state_o (kick_state)
  );

  assign kick_open = kick_state == KS_OPEN;

  // lock flag guarding the device-control register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_ok <= 1'b0;
    else if (we_i && hit_lock && kick_open) lock_ok <= (wdata_i == KEY_LOCK);
  end

  assign ctl_wr_ok = we_i && hit_ctl && kick_open && lock_ok;

  logic [CTL_W-1:0] ctl_rb;
  logic [STS_W-1:0] sts_rb;

  keyguard_devctl #(.N_DEV(NUM_DEV)) u_devctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctl_wr_ok),
    .wfields_i (wdata_i[CTL_W-1:0]),
    .en_o      (dev_en_o),
    .ctl_rb_o  (ctl_rb),
    .sts_o     (sts_rb)
  );

  // reset pulse register
  logic [RST_W-1:0] pulse_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= '0;
    else         pulse_q <= (we_i && hit_rst && kick_open) ? wdata_i[RST_W-1:0] : '0;
  end
  assign rst_pulse_o = pulse_q;

  // write-once word and sticky bits
  logic              once_wr;
  logic              once_done;
  logic [ONCE_W-1:0] once_val;
  logic [ONCE_W-1:0] once_sticky;
  assign once_wr = we_i && hit_once && kick_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      once_done   <= 1'b0;
      once_val    <= '0;
      once_sticky <= '0;
    end else if (once_wr) begin
      if (!once_done) begin
        once_val  <= wdata_i[ONCE_W-1:0];
        once_done <= 1'b1;
      end
      once_sticky <= once_sticky | wdata_i[2*ONCE_W-1:ONCE_W];
    end
  end

  // read mux, always available
  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      hit_ka:   rdata_o = DATA_W'(kick_state);
      hit_lock: rdata_o = DATA_W'(lock_ok);
      hit_ctl:  rdata_o = DATA_W'(ctl_rb);
      hit_sts:  rdata_o = DATA_W'(sts_rb);
      hit_once: rdata_o = DATA_W'({once_done, once_sticky, once_val});
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/keyguard_regbank_chk.sv
module keyguard_regbank_chk
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_DEV-1:0] dev_en_o,
  input logic [RST_W-1:0]   rst_pulse_o,
  input logic               kick_open,
  input logic               lock_ok,
  input logic               once_done,
  input logic [ONCE_W-1:0]  once_val
);
  // R2: opening only follows a correct second-key write
  assert_open_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kick_open) |-> $past(we_i && addr_i == ADDR_W'(OFS_KICK_B) && wdata_i == KEY_SECOND));

  // R4: device-control writes while closed change nothing
  assert_closed_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_DEVCTL) && !kick_open) |=> $stable(dev_en_o));

  // R5: device-control writes without the lock key change nothing
  assert_lock_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_DEVCTL) && !lock_ok) |=> $stable(dev_en_o));

  // R7: the non-disableable group never turns off
  assert_no_disable4_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_en_o[4] |=> dev_en_o[4]);
  assert_no_disable5_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_en_o[5] |=> dev_en_o[5]);

  // R9: a pulse only follows an accepted reset-register write
  assert_pulse_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pulse_o != '0) |-> $past(we_i && addr_i == ADDR_W'(OFS_RST) && kick_open));

  // R10: once written the frozen byte stays put
  assert_once_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    once_done |=> (once_done && $stable(once_val)));
endmodule

bind keyguard_regbank keyguard_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .dev_en_o    (dev_en_o),
  .rst_pulse_o (rst_pulse_o),
  .kick_open   (kick_open),
  .lock_ok     (lock_ok),
  .once_done   (once_done),
  .once_val    (once_val)
);

// File: tb/keyguard_regbank_bench.sv
module keyguard_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  dev_en;
  logic [7:0]  rst_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyguard_regbank u_keyguard_regbank (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dev_en_o(dev_en), .rst_pulse_o(rst_pulse)
  );

  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;
  localparam logic [31:0] LK = 32'h0F0A_0B00;

  // {write?, write addr, write data, read addr, expected read}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 32'h0,   8'h00, 32'h0},       // R1 idle after reset
    {1'b1, 8'h0C, 32'h1,   8'h0C, 32'h0},       // R4 closed
    {1'b1, 8'h00, KA,      8'h00, 32'h1},       // R2 first key
    {1'b1, 8'h04, KB,      8'h00, 32'h2},       // R2 open
    {1'b1, 8'h0C, 32'h1,   8'h0C, 32'h0},       // R5 no lock key
    {1'b1, 8'h08, LK,      8'h08, 32'h1},       // R5 lock key
    {1'b1, 8'h0C, 32'h3D9, 8'h0C, 32'h311},     // R6 R7 mixed codes
    {1'b0, 8'h00, 32'h0,   8'h10, 32'h1041},    // R8 status mirror
    {1'b1, 8'h0C, 32'h0,   8'h0C, 32'h300},     // R6 disable, R7 stays
    {1'b1, 8'h10, 32'hFFFF_FFFF, 8'h10, 32'h1000}, // R8 write ignored
    {1'b1, 8'h08, 32'h1234, 8'h08, 32'h0},      // R5 wrong lock
    {1'b1, 8'h0C, 32'h5,   8'h0C, 32'h300},     // R5 dropped
    {1'b1, 8'h18, 32'h5A5, 8'h18, 32'h105A5},   // R10 first write
    {1'b1, 8'h18, 32'hA3C, 8'h18, 32'h10FA5},   // R10 frozen + sticky
    {1'b1, 8'h18, 32'h0,   8'h18, 32'h10FA5},   // R10 sticky holds
    {1'b1, 8'h04, KB,      8'h00, 32'h0},       // R3 second key out of order
    {1'b1, 8'h00, KA,      8'h00, 32'h1},       // R2
    {1'b1, 8'h04, 32'h1234, 8'h00, 32'h0},      // R3 wrong second key
    {1'b1, 8'h00, KA,      8'h00, 32'h1},       // R2
    {1'b1, 8'h00, 32'h5555, 8'h00, 32'h0},      // R3 wrong first key
    {1'b1, 8'h14, 32'hFF,  8'h14, 32'h0},       // R4 R9 reads 0
    {1'b1, 8'h08, LK,      8'h08, 32'h0},       // R4 lock dropped
    {1'b1, 8'h18, 32'h7700, 8'h18, 32'h10FA5}   // R4 once dropped
  };
  localparam int VTAG [NVEC] = '{1,4,2,2,5,5,6,8,6,8,5,5,10,10,10,3,2,3,2,3,9,4,4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 dev_en", 32'(dev_en), 32'h0);
    check("R1 rst_pulse", 32'(rst_pulse), 32'h0);
    addr = 8'h18; #1;
    check("R1 once", rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][80]) bus_write(VEC[i][79:72], VEC[i][71:40]);
      else @(negedge clk);
      addr = VEC[i][39:32];
      #1;
      check($sformatf("R%0d vec%0d", VTAG[i], i), rdata, VEC[i][31:0]);
    end

    // R7 enable vector: only device 4 remains on
    check("R7 dev_en", 32'(dev_en), 32'h10);

    // R9 pulse lasts one cycle
    bus_write(8'h00, KA);
    bus_write(8'h04, KB);
    @(negedge clk);
    we = 1'b1; addr = 8'h14; wdata = 32'h81;
    @(negedge clk);
    we = 1'b0; #1;
    check("R9 pulse", 32'(rst_pulse), 32'h81);
    @(negedge clk); #1;
    check("R9 pulse end", 32'(rst_pulse), 32'h0);

    // R1 reset clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    check("R1 dev_en after reset", 32'(dev_en), 32'h0);
    addr = 8'h00; #1;
    check("R1 kick after reset", rdata, 32'h0);
    addr = 8'h18; #1;
    check("R1 once after reset", rdata, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule